// File: doc/BRIEF.md
# DRAM On-Die Termination Latency Pipeline

This block turns the termination request pin of a DDR3-style memory into the internal termination-enable signal, delayed by the programmed latency. The pin is sampled on every rising clock edge. The sampled value reappears on the enable output a fixed number of edges later. That number is the write latency minus two. The write latency is the CAS write latency plus the additive latency, and the additive latency is decoded from a two-bit mode field together with the CAS latency.

The pipeline runs only in synchronous termination mode. That mode needs the DLL to be locked and at least one termination setting (nominal or write) to be enabled. This covers bank-active, refresh and idle states with the clock enable high. It also covers active power-down, and precharge power-down while the DLL stays on. The caller expresses all of these through the same two conditions. Outside this mode the output is held low and every sample in flight is discarded. New latency settings take effect only when no transition is pending, so a change of setting cannot shift an edge that is already queued.

Top module: `odt_latency_pipe`

## Requirements
- R1: `sync_mode_o` is high exactly when `dll_locked_i` is high and at least one of `rtt_nom_en_i` or `rtt_wr_en_i` is high.
- R2: In synchronous mode, `rtt_en_o` goes high on the D-th rising edge after the edge that sampled `odt_i` high. Here D is the active delay, D = CWL + AL - 2.
- R3: In synchronous mode, `rtt_en_o` goes low on the D-th rising edge after the edge that sampled `odt_i` low, where D is the same active delay.
- R4: The additive latency is decoded from `al_field_i` as follows: 2'b00 gives 0, 2'b01 gives CL-1, 2'b10 gives CL-2, and 2'b11 (reserved) gives 0. A negative result is taken as 0.
- R5: A computed delay below 1 is clamped to 1. A computed delay above the pipeline depth (16 by default) is clamped to the depth.
- R6: While synchronous mode is inactive, `rtt_en_o` is low. Samples taken before the mode dropped never appear on `rtt_en_o` after the mode returns.
- R7: New values on `cwl_i`, `cl_i` and `al_field_i` are adopted only on an edge where no sampled high value is still in flight and `rtt_en_o` is low. Until then the old delay governs all pending transitions.
- R8: While `rst_ni` is low, `rtt_en_o` is low and no samples are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| odt_i | input | 1 | External termination request pin |
| cwl_i | input | 4 | CAS write latency in cycles |
| cl_i | input | 5 | CAS latency in cycles |
| al_field_i | input | 2 | Additive latency mode field |
| dll_locked_i | input | 1 | DLL enabled and locked |
| rtt_nom_en_i | input | 1 | Nominal termination enabled |
| rtt_wr_en_i | input | 1 | Write termination enabled |
| rtt_en_o | output | 1 | Delayed termination enable |
| sync_mode_o | output | 1 | Synchronous termination mode active |

## Verification
A wrong tap or a wrong latency decode moves every edge of `rtt_en_o` by a whole cycle. This shows up at the first request after the setting is adopted, within D+1 cycles. A flush that fails leaves stale highs in the shift chain, and these leak onto the output within the depth of the pipeline once the mode returns. Adopting the latency early lets a falling edge that is already queued come out at the new delay, which the bench sees as a pulse that is too short or too long. A reference model compared on every clock catches each of these on the first affected edge.

// File: rtl/odt_pkg.sv
package odt_pkg;
  typedef enum logic [1:0] {
    AL_NONE   = 2'b00,
    AL_CL_M1  = 2'b01,
    AL_CL_M2  = 2'b10,
    AL_RSVD   = 2'b11
  } al_mode_e;
endpackage

// File: rtl/odt_al_decode.sv
module odt_al_decode
  import odt_pkg::*;
#(
  parameter int CL_W = 5
) (
  input  logic [1:0]      al_field_i,
  input  logic [CL_W-1:0] cl_i,
  output logic [CL_W-1:0] al_o
);
  al_mode_e mode;
  assign mode = al_mode_e'(al_field_i);

  always_comb begin
    unique case (mode)
      AL_CL_M1: al_o = (cl_i >= CL_W'(1)) ? cl_i - CL_W'(1) : '0;
      AL_CL_M2: al_o = (cl_i >= CL_W'(2)) ? cl_i - CL_W'(2) : '0;
      default:  al_o = '0;
    endcase
  end

  // R4
  always_comb begin
    al_le_cl_chk: assert (al_o <= cl_i);
  end
endmodule

// File: rtl/odt_lat_ctrl.sv
module odt_lat_ctrl #(
  parameter int CWL_W = 4,
  parameter int CL_W  = 5,
  parameter int DEPTH = 16,
  parameter int DLY_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CWL_W-1:0] cwl_i,
  input  logic [CL_W-1:0]  al_i,
  input  logic             empty_i,
  output logic [DLY_W-1:0] dly_o
);
  localparam int MAXW  = (CWL_W > CL_W) ? CWL_W : CL_W;
  localparam int SUM_W = MAXW + 2;

  logic [SUM_W-1:0] wl;
  logic [DLY_W-1:0] dly_n, dly_q;

  assign wl = SUM_W'(cwl_i) + SUM_W'(al_i);

  always_comb begin
    if (wl < SUM_W'(3))
      dly_n = DLY_W'(1);
    else if (wl - SUM_W'(2) > SUM_W'(DEPTH))
      dly_n = DLY_W'(DEPTH);
    else
      dly_n = DLY_W'(wl - SUM_W'(2));
  end

  // adopt new latency only with nothing in flight
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      dly_q <= DLY_W'(1);
    else if (empty_i) dly_q <= dly_n;
  end

  assign dly_o = dly_q;

  // R7
  dly_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !empty_i |=> $stable(dly_q));
  // R5
  dly_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dly_q >= DLY_W'(1)) && (dly_q <= DLY_W'(DEPTH)));
endmodule

// File: rtl/odt_delay_line.sv
module odt_delay_line #(
  parameter int DEPTH = 16,
  parameter int DLY_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             odt_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             tap_o,
  output logic             empty_o
);
  logic [DEPTH-1:0] sr_q;
  logic             tap_q;
  logic             sel;
  logic [DLY_W-1:0] idx;

  assign idx = dly_i - DLY_W'(1);

  always_comb begin
    sel = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (idx == DLY_W'(i)) sel = sr_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      tap_q <= 1'b0;
    end else if (!en_i) begin
      sr_q  <= '0;
      tap_q <= 1'b0;
    end else begin
      sr_q  <= {sr_q[DEPTH-2:0], odt_i};
      tap_q <= sel;
    end
  end

  assign tap_o   = tap_q;
  assign empty_o = (sr_q == '0) && !tap_q;

  // R2
  sample_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> sr_q[0] == $past(odt_i));
  // R6
  flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !tap_o);
endmodule

// File: rtl/odt_latency_pipe.sv
module odt_latency_pipe #(
  parameter int CWL_W = 4,
  parameter int CL_W  = 5,
  parameter int DEPTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             odt_i,
  input  logic [CWL_W-1:0] cwl_i,
  input  logic [CL_W-1:0]  cl_i,
  input  logic [1:0]       al_field_i,
  input  logic             dll_locked_i,
  input  logic             rtt_nom_en_i,
  input  logic             rtt_wr_en_i,
  output logic             rtt_en_o,
  output logic             sync_mode_o
);
  localparam int DLY_W = $clog2(DEPTH + 1);

  logic             sync_mode;
  logic [CL_W-1:0]  al;
  logic [DLY_W-1:0] dly;
  logic             tap, empty;

  assign sync_mode = dll_locked_i && (rtt_nom_en_i || rtt_wr_en_i);

  odt_al_decode #(.CL_W(CL_W)) u_al (
    .al_field_i (al_field_i),
    .cl_i       (cl_i),
    .al_o       (al)
  );

  odt_lat_ctrl #(.CWL_W(CWL_W), .CL_W(CL_W), .DEPTH(DEPTH), .DLY_W(DLY_W)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cwl_i   (cwl_i),
    .al_i    (al),
    .empty_i (empty),
    .dly_o   (dly)
  );

  odt_delay_line #(.DEPTH(DEPTH), .DLY_W(DLY_W)) u_line (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (sync_mode),
    .odt_i   (odt_i),
    .dly_i   (dly),
    .tap_o   (tap),
    .empty_o (empty)
  );

  assign rtt_en_o    = tap && sync_mode;
  assign sync_mode_o = sync_mode;

  // R1
  sync_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dll_locked_i |-> !rtt_en_o);
endmodule

// File: tb/odt_latency_pipe_test.sv
module odt_latency_pipe_test;
  localparam int DEPTH = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic odt = 1'b0;
  logic [3:0] cwl = 4'd5;
  logic [4:0] cl = 5'd6;
  logic [1:0] alf = 2'b00;
  logic dll = 1'b1, nom = 1'b1, wr = 1'b0;
  logic rtt, sync_o;

  int tests = 0, fails = 0;
  string cur_req = "R2";
  bit cmp_en = 1'b0;

  always #10 clk = ~clk;

  odt_latency_pipe uut (
    .clk_i(clk), .rst_ni(rst_n), .odt_i(odt), .cwl_i(cwl), .cl_i(cl),
    .al_field_i(alf), .dll_locked_i(dll), .rtt_nom_en_i(nom), .rtt_wr_en_i(wr),
    .rtt_en_o(rtt), .sync_mode_o(sync_o)
  );

  function automatic int exp_dly(int c_wl, int c_l, int f);
    int a, d;
    a = (f == 1) ? c_l - 1 : (f == 2) ? c_l - 2 : 0;
    if (a < 0) a = 0;
    d = c_wl + a - 2;
    if (d < 1) d = 1;
    if (d > DEPTH) d = DEPTH;
    return d;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference
  bit hist[$];
  bit m_rtt;
  int m_dly;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist.delete(); m_rtt = 0; m_dly = 1;
    end else begin
      bit empty;
      int nd;
      empty = !m_rtt;
      foreach (hist[i]) if (hist[i]) empty = 0;
      nd = exp_dly(cwl, cl, alf);
      if (dll && (nom || wr)) begin
        m_rtt = (hist.size() >= m_dly) ? hist[m_dly-1] : 1'b0;
        hist.push_front(odt);
        if (hist.size() > DEPTH) void'(hist.pop_back());
      end else begin
        m_rtt = 0; hist.delete();
      end
      if (empty) m_dly = nd;
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      bit s;
      s = dll && (nom || wr);
      chk(rtt === (m_rtt && s), cur_req, "rtt_en vs model", int'(rtt), int'(m_rtt && s));
      chk(sync_o === s, "R1", "sync_mode", int'(sync_o), int'(s));
    end
  end

  task automatic measure(bit lvl, output int n);
    n = 0;
    @(negedge clk) odt = lvl;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (rtt !== lvl && n < 40);
    n = n - 1;
  endtask

  task automatic drain();
    @(negedge clk) odt = 0;
    repeat (DEPTH + 3) @(negedge clk);
  endtask

  task automatic lat_case(int c_wl, int c_l, int f, string req);
    int n, e;
    drain();
    cwl = 4'(c_wl); cl = 5'(c_l); alf = 2'(f);
    repeat (2) @(negedge clk);
    e = exp_dly(c_wl, c_l, f);
    cur_req = req;
    measure(1'b1, n);
    chk(n == e, req, "turn-on delay", n, e);
    repeat (3) @(negedge clk);
    measure(1'b0, n);
    chk(n == e, "R3", "turn-off delay", n, e);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    bit seen;
    repeat (3) @(negedge clk);
    // R8
    chk(rtt === 1'b0, "R8", "rtt during reset", int'(rtt), 0);
    odt = 1;
    repeat (2) @(negedge clk);
    chk(rtt === 1'b0, "R8", "rtt held in reset", int'(rtt), 0);
    odt = 0;
    rst_n = 1;
    cmp_en = 1;
    repeat (2) @(negedge clk);

    // R1 combinations
    for (int i = 0; i < 8; i++) begin
      @(negedge clk) {dll, nom, wr} = 3'(i);
      #1 chk(sync_o === (dll && (nom || wr)), "R1", "sync combo", int'(sync_o), int'(dll && (nom || wr)));
    end
    @(negedge clk) {dll, nom, wr} = 3'b101;

    // R2/R3 basic, R4 decode, R5 clamp
    lat_case(5, 6, 0, "R2");
    lat_case(5, 6, 1, "R4");
    lat_case(5, 6, 2, "R4");
    lat_case(5, 6, 3, "R4");
    lat_case(7, 1, 2, "R4");
    lat_case(1, 6, 0, "R5");
    lat_case(2, 6, 0, "R5");
    lat_case(15, 16, 1, "R5");

    // R7: change latency while high is in flight
    lat_case(5, 6, 0, "R7");
    drain();
    cur_req = "R7";
    measure(1'b1, n);
    chk(n == 3, "R7", "on delay before change", n, 3);
    repeat (2) @(negedge clk);
    cwl = 4'd9;
    measure(1'b0, n);
    chk(n == 3, "R7", "pending fall uses old delay", n, 3);
    repeat (DEPTH + 3) @(negedge clk);
    measure(1'b1, n);
    chk(n == 7, "R7", "new delay after drain", n, 7);
    drain();

    // R6: drop sync with samples in flight
    cur_req = "R6";
    cwl = 4'd10; repeat (2) @(negedge clk);
    odt = 1; repeat (4) @(negedge clk);
    dll = 0;
    @(negedge clk);
    chk(rtt === 1'b0, "R6", "rtt low while unsynced", int'(rtt), 0);
    odt = 0; dll = 1;
    seen = 0;
    for (int i = 0; i < DEPTH + 3; i++) begin
      @(negedge clk);
      if (rtt) seen = 1;
    end
    chk(!seen, "R6", "no stale pulse after flush", int'(seen), 0);
    nom = 0; wr = 1; odt = 1;
    repeat (3) @(negedge clk);
    wr = 0;
    @(negedge clk);
    chk(rtt === 1'b0, "R6", "rtt low with termination off", int'(rtt), 0);
    wr = 1; odt = 0;
    drain();

    // mixed traffic, model compared every clock
    cur_req = "R3";
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      odt = ($urandom_range(0, 3) == 0) ? ~odt : odt;
      if ($urandom_range(0, 40) == 0) begin
        cwl = 4'($urandom_range(0, 15)); cl = 5'($urandom_range(0, 20));
        alf = 2'($urandom_range(0, 3));
      end
      if ($urandom_range(0, 60) == 0) dll = ~dll;
      if ($urandom_range(0, 80) == 0) nom = ~nom;
    end
    dll = 1; nom = 1;
    drain();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule